// File: doc/BRIEF.md
# S/PDIF Sample-Rate Mode Detector

This block estimates the sample rate of an incoming S/PDIF line without a PLL and without decoding frames. The serial line is sampled by a fast reference clock, resynchronised, and every transition is timestamped against the previous one. Over a programmable window of reference-clock cycles the block tracks the shortest and the longest edge-to-edge interval. When the window closes, the selected interval is classified against a ladder of six programmable thresholds into one of seven rate modes. If no interval was measured, the block reports "no signal".

Software programs the window length, typically refclk/1000 for a 1 ms update, and the threshold ladder. The threshold for mode i is the sum of the nominal 1/128-frame cell widths of modes i and i+1. The block compares twice the measured width against each threshold, so every threshold falls midway between two neighbouring nominal widths. A single-cycle pulse flags each window whose result differs from the previous one.

Top module: `spdif_rate_detect`

## Requirements
- R1: A transition on `line_i` passes a two-flop synchroniser. The interval between two consecutive transitions is counted in clock cycles, so transitions N cycles apart give a width of N. With `width_sel_i`=1, `width_o` reports the smallest interval of the last window.
- R2: With `width_sel_i`=0, the largest interval of the window is reported and classified instead of the smallest.
- R3: A window lasts `window_len_i` cycles. `mode_o` and `width_o` change only in the cycle after a window ends. The minimum tracker restarts from all ones and the maximum tracker from zero at every window start, so a window's result depends only on intervals that end inside it.
- R4: Mode codes 0..6 stand for 32000, 44100, 48000, 88200, 96000, 176400 and 192000 Hz. For the selected width w, the result is the lowest i in 0..5 with 2*w >= threshold i, and 6 if no such i exists. Thresholds 0, 1 and 2 sit in `thr_a_i` at bits [29:20], [19:10] and [9:0]. Thresholds 3, 4 and 5 sit in `thr_b_i` at the same positions.
- R5: A window in which no interval completed yields mode code 7 and `width_o`=0. A width of 0 occurs only together with code 7.
- R6: The interval counter saturates at 2^WID_W-1 (1023 by default) instead of wrapping. A longer gap reports 1023.
- R7: `mode_chg_o` pulses for exactly one cycle, together with the update, whenever a window result differs from the current `mode_o`. It stays low while the result repeats.
- R8: While `enable_i` is low, from the next cycle on, `mode_o`=7, `width_o`=0 and `mode_chg_o` stays low. After `enable_i` rises again, measurement restarts from scratch.
- R9: After reset, `mode_o`=7, `width_o`=0 and `mode_chg_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Asynchronous S/PDIF serial line |
| enable_i | input | 1 | Detector enable |
| width_sel_i | input | 1 | 1: classify the minimum interval, 0: the maximum |
| window_len_i | input | WIN_W (20) | Window length in clock cycles |
| thr_a_i | input | 3*THR_W (30) | Thresholds of modes 0..2, mode 0 in the top field |
| thr_b_i | input | 3*THR_W (30) | Thresholds of modes 3..5, mode 3 in the top field |
| mode_o | output | 3 | Detected mode code, 7 for no signal |
| width_o | output | WID_W (10) | Measured width of the last window |
| mode_chg_o | output | 1 | One-cycle pulse on a change of mode |

## Verification
The bench builds the block with its default widths: a 20-bit window, a 10-bit interval counter and 10-bit thresholds. It programs a 300-cycle window for the ladder sweep, where even the slowest mode still completes several intervals per window. It then programs a 4000-cycle window, which lets a single interval exceed 1023 cycles and reach saturation within a short run. The threshold ladder is set from nominal cell widths of 64 down to 11 cycles. Square and asymmetric waves then hit each mode, both exact ties on the doubled-width comparison, and the min/max selection.

// File: rtl/spdif_rd_pkg.sv
package spdif_rd_pkg;
  localparam int NUM_MODES = 7;
  localparam int NUM_THR   = NUM_MODES - 1;
  localparam int THR_PER_W = 3;
  localparam int MODE_W    = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_32K   = 3'd0,
    MODE_44K1  = 3'd1,
    MODE_48K   = 3'd2,
    MODE_88K2  = 3'd3,
    MODE_96K   = 3'd4,
    MODE_176K4 = 3'd5,
    MODE_192K  = 3'd6,
    MODE_NONE  = 3'd7
  } rate_mode_e;
endpackage

// File: rtl/spdif_line_sync.sv
module spdif_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = s2_q ^ s3_q;
endmodule

// File: rtl/spdif_interval_meter.sv
module spdif_interval_meter #(
  parameter int WIN_W = 20,
  parameter int WID_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             edge_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             win_end_o,
  output logic             any_o,
  output logic [WID_W-1:0] min_o,
  output logic [WID_W-1:0] max_o
);
  localparam logic [WID_W-1:0] WID_MAX = '1;

  logic [WID_W-1:0] run_q, min_q, max_q, min_d, max_d;
  logic [WIN_W-1:0] win_q;
  logic             prev_q, any_q, iv_ok;

  // interval closes on an edge only if an earlier edge opened it
  assign iv_ok = en_i && edge_i && prev_q;
  assign min_d = (iv_ok && run_q < min_q) ? run_q : min_q;
  assign max_d = (iv_ok && run_q > max_q) ? run_q : max_q;
  assign win_end_o = en_i && (({1'b0, win_q} + 1'b1) >= {1'b0, win_len_i});
  assign any_o = any_q | iv_ok;
  assign min_o = min_d;
  assign max_o = max_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      prev_q <= 1'b0;
    end else if (!en_i) begin
      run_q  <= '0;
      prev_q <= 1'b0;
    end else if (edge_i) begin
      run_q  <= WID_W'(1);
      prev_q <= 1'b1;
    end else if (run_q != WID_MAX) begin
      run_q  <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      min_q <= WID_MAX;
      max_q <= '0;
      any_q <= 1'b0;
    end else if (!en_i || win_end_o) begin
      win_q <= '0;
      min_q <= WID_MAX;
      max_q <= '0;
      any_q <= 1'b0;
    end else begin
      win_q <= win_q + 1'b1;
      min_q <= min_d;
      max_q <= max_d;
      any_q <= any_o;
    end
  end
endmodule

// File: rtl/spdif_rate_ladder.sv
module spdif_rate_ladder
  import spdif_rd_pkg::*;
#(
  parameter int WID_W = 10,
  parameter int THR_W = 10
) (
  input  logic [WID_W-1:0]           width_i,
  input  logic                       any_i,
  input  logic [THR_PER_W*THR_W-1:0] thr_a_i,
  input  logic [THR_PER_W*THR_W-1:0] thr_b_i,
  output rate_mode_e                 mode_o
);
  localparam int CMP_W = ((WID_W + 1) > (THR_W + 1)) ? (WID_W + 1) : (THR_W + 1);

  logic [NUM_THR-1:0] hit;
  logic [CMP_W-1:0]   dbl_w;

  assign dbl_w = CMP_W'({width_i, 1'b0});

  for (genvar i = 0; i < NUM_THR; i++) begin : g_rung
    localparam int SLOT = THR_PER_W - 1 - (i % THR_PER_W);
    logic [THR_W-1:0] thr;
    if (i < THR_PER_W) begin : g_a
      assign thr = thr_a_i[SLOT*THR_W +: THR_W];
    end else begin : g_b
      assign thr = thr_b_i[SLOT*THR_W +: THR_W];
    end
    assign hit[i] = dbl_w >= CMP_W'(thr);
  end

  always_comb begin
    mode_o = MODE_192K;
    for (int i = NUM_THR - 1; i >= 0; i--) begin
      if (hit[i]) mode_o = rate_mode_e'(i);
    end
    if (!any_i) mode_o = MODE_NONE;
  end
endmodule

// File: rtl/spdif_rate_detect.sv
module spdif_rate_detect
  import spdif_rd_pkg::*;
#(
  parameter int WIN_W = 20,
  parameter int WID_W = 10,
  parameter int THR_W = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   line_i,
  input  logic                   enable_i,
  input  logic                   width_sel_i,
  input  logic [WIN_W-1:0]       window_len_i,
  input  logic [3*THR_W-1:0]     thr_a_i,
  input  logic [3*THR_W-1:0]     thr_b_i,
  output logic [2:0]             mode_o,
  output logic [WID_W-1:0]       width_o,
  output logic                   mode_chg_o
);
  logic             edge_s, win_end, any_iv;
  logic [WID_W-1:0] min_w, max_w, sel_w;
  rate_mode_e       new_mode;

  spdif_line_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .edge_o (edge_s)
  );

  spdif_interval_meter #(.WIN_W(WIN_W), .WID_W(WID_W)) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (enable_i),
    .edge_i    (edge_s),
    .win_len_i (window_len_i),
    .win_end_o (win_end),
    .any_o     (any_iv),
    .min_o     (min_w),
    .max_o     (max_w)
  );

  assign sel_w = width_sel_i ? min_w : max_w;

  spdif_rate_ladder #(.WID_W(WID_W), .THR_W(THR_W)) u_ladder (
    .width_i (sel_w),
    .any_i   (any_iv),
    .thr_a_i (thr_a_i),
    .thr_b_i (thr_b_i),
    .mode_o  (new_mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= MODE_NONE;
      width_o    <= '0;
      mode_chg_o <= 1'b0;
    end else if (!enable_i) begin
      mode_o     <= MODE_NONE;
      width_o    <= '0;
      mode_chg_o <= 1'b0;
    end else if (win_end) begin
      mode_o     <= new_mode;
      width_o    <= any_iv ? sel_w : '0;
      mode_chg_o <= (new_mode != mode_o);
    end else begin
      mode_chg_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spdif_rate_detect_chk.sv
module spdif_rate_detect_chk #(
  parameter int WID_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             win_end_i,
  input logic [2:0]       mode_i,
  input logic [WID_W-1:0] width_i,
  input logic             chg_i
);
  p_none_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_i == '0) == (mode_i == 3'd7));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !win_end_i) |=> ($stable(mode_i) && $stable(width_i)));

  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && win_end_i) |=> (chg_i == (mode_i != $past(mode_i))));

  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enable_i && win_end_i) |=> !chg_i);

  p_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (mode_i == 3'd7 && width_i == '0 && !chg_i));
endmodule

bind spdif_rate_detect spdif_rate_detect_chk #(.WID_W(WID_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .win_end_i (win_end),
  .mode_i    (mode_o),
  .width_i   (width_o),
  .chg_i     (mode_chg_o)
);

// File: tb/spdif_rate_detect_tb.sv
`timescale 1ns/1ps
module spdif_rate_detect_tb;
  localparam int NV = 12;
  // hi, lo, width_sel, expected mode, expected width
  localparam int VEC [NV][5] = '{
    '{64, 64, 1, 0, 64}, '{46, 46, 1, 1, 46}, '{42, 42, 1, 2, 42},
    '{23, 23, 1, 3, 23}, '{21, 21, 1, 4, 21}, '{12, 12, 1, 5, 12},
    '{11, 11, 1, 6, 11}, '{55, 55, 1, 0, 55}, '{44, 44, 1, 1, 44},
    '{12, 46, 1, 5, 12}, '{12, 46, 0, 1, 46}, '{46, 46, 1, 1, 46}
  };

  logic        clk = 1'b0, rst_ni = 1'b0, line = 1'b0, enable = 1'b0, wsel = 1'b1;
  logic [19:0] win_len = 20'd300;
  logic [29:0] thr_a = {10'd110, 10'd88, 10'd65};
  logic [29:0] thr_b = {10'd44, 10'd33, 10'd23};
  logic [2:0]  mode;
  logic [9:0]  width;
  logic        chg;
  int checks = 0, bad = 0, pulses = 0;
  int hi_len = 64, lo_len = 64;
  bit wave_on = 0, done = 0;

  always #4 clk = ~clk;

  spdif_rate_detect u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .line_i (line), .enable_i (enable),
    .width_sel_i (wsel), .window_len_i (win_len), .thr_a_i (thr_a),
    .thr_b_i (thr_b), .mode_o (mode), .width_o (width), .mode_chg_o (chg)
  );

  always @(negedge clk) if (chg) pulses++;

  initial begin
    forever begin
      if (wave_on) begin
        line = 1'b1;
        repeat (hi_len) @(negedge clk);
        line = 1'b0;
        repeat (lo_len) @(negedge clk);
      end else @(negedge clk);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int p0, prev_mode;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9 mode", mode, 7);
    chk("R9 width", width, 0);
    chk("R9 pulse", chg, 0);

    enable = 1'b1;
    prev_mode = 7;
    for (int v = 0; v < NV; v++) begin
      hi_len = VEC[v][0];
      lo_len = VEC[v][1];
      wsel = VEC[v][2][0];
      wave_on = 1;
      p0 = pulses;
      repeat (1200) @(negedge clk);
      chk("R4 mode", mode, VEC[v][3]);
      chk(VEC[v][2] == 1 ? "R1 min width (R3 tracker restart)" : "R2 max width", width, VEC[v][4]);
      if (VEC[v][3] != prev_mode) chk("R7 pulse on change", int'(pulses > p0), 1);
      p0 = pulses;
      repeat (600) @(negedge clk);
      chk("R3 result held", mode, VEC[v][3]);
      chk("R7 no pulse while steady", pulses - p0, 0);
      prev_mode = VEC[v][3];
    end

    // saturation
    wsel = 1'b1;
    win_len = 20'd4000;
    hi_len = 1500;
    lo_len = 1500;
    repeat (24000) @(negedge clk);
    chk("R6 saturated width", width, 1023);
    chk("R6 mode", mode, 0);

    // no signal
    win_len = 20'd300;
    wave_on = 0;
    p0 = pulses;
    repeat (3000) @(negedge clk);
    chk("R5 mode", mode, 7);
    chk("R5 width", width, 0);
    chk("R7 pulse into no-signal", int'(pulses > p0), 1);

    // disable / re-enable
    hi_len = 21;
    lo_len = 21;
    wave_on = 1;
    repeat (1200) @(negedge clk);
    chk("R4 mode before disable", mode, 4);
    p0 = pulses;
    enable = 1'b0;
    @(negedge clk);
    chk("R8 mode off", mode, 7);
    chk("R8 width off", width, 0);
    repeat (10) @(negedge clk);
    chk("R8 no pulse", pulses - p0, 0);
    enable = 1'b1;
    repeat (1200) @(negedge clk);
    chk("R8 restart mode", mode, 4);
    chk("R8 restart width", width, 21);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule